// File: doc/BRIEF.md
# Per-Sender Receive Window Address Allocator

This block produces the bus write address for each message one board sends to another over a shared backplane bus. Every destination slot owns a contiguous region of bus address space. The region's size is a power of two. It is cut into equal sub-windows, one for each slot that could send, so two senders can never write over each other's data. The local board uses the sub-window whose index matches its own slot number.

For each destination, the block keeps a running write offset inside the local board's sub-window. A request names a destination slot and a byte length. One cycle later the block pulses a grant with the absolute address to write at, and moves the offset forward. If the space left in the sub-window is too small for the message, the message starts again at offset zero. A message is therefore never split across the wrap point. A message larger than the whole sub-window is refused, and the offset is not touched.

Software loads each slot's base address and region size through a write port. It can read any slot's current offset back through a separate read port.

Top module: `rxwin_alloc`

## Requirements
- R1: After reset, every destination's offset reads back as zero on `rd_offset`.
- R2: A request that is accepted is answered with `grant` high for exactly one cycle, in the cycle after `req_valid` was sampled. `reject` is low in that cycle.
- R3: The sub-window size is 2^`cfg_range_log2` / 8, which is 0 when `cfg_range_log2` < 3. `grant_addr` = base + `own_slot` × sub-window size + the offset in effect. All arithmetic is modulo 2^32.
- R4: If the length is at most the sub-window size minus the current offset, the message is written at the current offset, and the offset then grows by the length. A message that fills the space left exactly does not wrap.
- R5: If the length is at most the sub-window size but larger than the space left, the message is written at offset 0, and the offset becomes equal to the length.
- R6: A length larger than the sub-window size gives a one-cycle `reject` pulse in the cycle after the request, with no grant. The destination's offset does not change.
- R7: A request changes only the offset of its own destination. The offsets of all other destinations keep their values.
- R8: A configuration write stores the slot's base and range. It also sets that slot's offset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot being configured |
| cfg_base | input | 32 | Base bus address of that slot's region |
| cfg_range_log2 | input | 5 | Region size given as a power of two |
| rd_slot | input | 3 | Slot whose offset is read back |
| rd_offset | output | 32 | Current offset of `rd_slot` |
| own_slot | input | 3 | Slot number of the local board, which selects its sub-window |
| req_valid | input | 1 | Transfer request strobe |
| req_dst | input | 3 | Destination slot of the request |
| req_len | input | 16 | Message length in bytes |
| grant | output | 1 | One-cycle pulse: request accepted |
| grant_addr | output | 32 | Absolute write address, valid while `grant` is high |
| reject | output | 1 | One-cycle pulse: message larger than the sub-window |

## Verification
A corrupted offset entry shows up on the very next request to that destination. The grant address is then wrong by the size of the error, and the wrap decision may flip, so a wrap that should happen does not, or a wrap happens too early. The same fault is visible at once on the `rd_offset` read port. A write that lands on the wrong slot shows up as a change in some other destination's readback, and the bench reads every slot back to catch it. A wrong sub-window calculation moves every grant address by a multiple of the sub-window size. It also moves where rejection starts, so a message that exactly fills the sub-window is tested on both sides of that limit.

// File: rtl/rxwin_pkg.sv
package rxwin_pkg;
    localparam int NUM_SLOTS = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int ADDR_W    = 32;
    localparam int LEN_W     = 16;
    localparam int LOG_W     = $clog2(ADDR_W);

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [LOG_W-1:0]  lg_t;

    typedef struct packed {
        addr_t base;
        lg_t   lg;
    } win_cfg_t;

    typedef struct packed {
        logic  refuse;
        addr_t eff_off;
        addr_t next_off;
    } fit_res_t;

    function automatic addr_t sub_size(lg_t lg);
        if (lg < lg_t'(SLOT_W))
            return '0;
        return addr_t'(1) << (lg - lg_t'(SLOT_W));
    endfunction
endpackage

// File: rtl/rxwin_cfg_table.sv
module rxwin_cfg_table
    import rxwin_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  slot_t                      slot,
    input  win_cfg_t                   wdata,
    output win_cfg_t [NUM_SLOTS-1:0]   cfg_vec
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                cfg_vec[s] <= '0;
            else if (we && slot == slot_t'(s))
                cfg_vec[s] <= wdata;
        end
    end
endmodule

// File: rtl/rxwin_offset_table.sv
module rxwin_offset_table
    import rxwin_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_en,
    input  slot_t                    clr_slot,
    input  logic                     upd_en,
    input  slot_t                    upd_slot,
    input  addr_t                    upd_val,
    output addr_t [NUM_SLOTS-1:0]    off_vec
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                off_vec[s] <= '0;
            else if (clr_en && clr_slot == slot_t'(s))
                off_vec[s] <= '0;
            else if (upd_en && upd_slot == slot_t'(s))
                off_vec[s] <= upd_val;
        end
    end
endmodule

// File: rtl/rxwin_fit.sv
module rxwin_fit
    import rxwin_pkg::*;
(
    input  addr_t    cur_off,
    input  addr_t    sub,
    input  len_t     len,
    output fit_res_t res
);
    addr_t len_x;
    addr_t room;

    always_comb begin
        len_x = addr_t'(len);
        room  = (cur_off > sub) ? '0 : sub - cur_off;
        res   = '0;
        if (len_x > sub) begin
            res.refuse   = 1'b1;
            res.eff_off  = cur_off;
            res.next_off = cur_off;
        end else if (len_x > room) begin
            res.eff_off  = '0;
            res.next_off = len_x;
        end else begin
            res.eff_off  = cur_off;
            res.next_off = cur_off + len_x;
        end
    end
endmodule

// File: rtl/rxwin_alloc.sv
module rxwin_alloc
    import rxwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_slot,
    input  logic [31:0] cfg_base,
    input  logic [4:0]  cfg_range_log2,
    input  logic [2:0]  rd_slot,
    output logic [31:0] rd_offset,
    input  logic [2:0]  own_slot,
    input  logic        req_valid,
    input  logic [2:0]  req_dst,
    input  logic [15:0] req_len,
    output logic        grant,
    output logic [31:0] grant_addr,
    output logic        reject
);
    win_cfg_t [NUM_SLOTS-1:0] cfg_vec;
    addr_t    [NUM_SLOTS-1:0] off_vec;
    win_cfg_t cfg_wdata;
    win_cfg_t sel_cfg;
    addr_t    sel_sub;
    fit_res_t fit;
    addr_t    addr_c;

    assign cfg_wdata.base = cfg_base;
    assign cfg_wdata.lg   = cfg_range_log2;

    rxwin_cfg_table u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .slot    (cfg_slot),
        .wdata   (cfg_wdata),
        .cfg_vec (cfg_vec)
    );

    assign sel_cfg = cfg_vec[req_dst];
    assign sel_sub = sub_size(sel_cfg.lg);

    rxwin_fit u_fit (
        .cur_off (off_vec[req_dst]),
        .sub     (sel_sub),
        .len     (req_len),
        .res     (fit)
    );

    rxwin_offset_table u_off (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (cfg_we),
        .clr_slot (cfg_slot),
        .upd_en   (req_valid && !fit.refuse),
        .upd_slot (req_dst),
        .upd_val  (fit.next_off),
        .off_vec  (off_vec)
    );

    assign addr_c    = sel_cfg.base + addr_t'(own_slot) * sel_sub + fit.eff_off;
    assign rd_offset = off_vec[rd_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            grant      <= 1'b0;
            reject     <= 1'b0;
            grant_addr <= '0;
        end else begin
            grant      <= req_valid && !fit.refuse;
            reject     <= req_valid && fit.refuse;
            grant_addr <= addr_c;
        end
    end

    // Grant and reject are mutually exclusive responses
    assert_resp_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(grant && reject));

    // A grant always answers a request sampled one cycle earlier
    assert_grant_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        grant |-> $past(req_valid));

    // A refused request leaves its destination offset untouched
    assert_reject_keeps_offset_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fit.refuse && !cfg_we) |=>
            (off_vec[$past(req_dst)] == $past(off_vec[req_dst])));

    // Offset table never runs past the sub-window of the stored configuration
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
        assert_offset_in_window_R4: assert property (@(posedge clk) disable iff (rst)
            off_vec[s] <= sub_size(cfg_vec[s].lg));
    end

    // A wrapped message starts at the sub-window origin
    assert_wrap_origin_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !fit.refuse && !cfg_we &&
         addr_t'(req_len) > sel_sub - off_vec[req_dst]) |=>
            (off_vec[$past(req_dst)] == addr_t'($past(req_len))));
endmodule

// File: tb/rxwin_alloc_test.sv
module rxwin_alloc_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_slot;
    logic [31:0] cfg_base;
    logic [4:0]  cfg_range_log2;
    logic [2:0]  rd_slot;
    logic [31:0] rd_offset;
    logic [2:0]  own_slot;
    logic        req_valid;
    logic [2:0]  req_dst;
    logic [15:0] req_len;
    logic        grant;
    logic [31:0] grant_addr;
    logic        reject;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_base [8];
    logic [4:0]  m_lg   [8];
    logic [31:0] m_off  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxwin_alloc uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_base(cfg_base),
        .cfg_range_log2(cfg_range_log2),
        .rd_slot(rd_slot), .rd_offset(rd_offset),
        .own_slot(own_slot),
        .req_valid(req_valid), .req_dst(req_dst), .req_len(req_len),
        .grant(grant), .grant_addr(grant_addr), .reject(reject)
    );

    function automatic logic [31:0] m_sub(logic [4:0] lg);
        if (lg < 5'd3) return 32'd0;
        return 32'd1 << (lg - 5'd3);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic configure(int s, logic [31:0] b, logic [4:0] lg);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 3'(s); cfg_base = b; cfg_range_log2 = lg;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[s] = b; m_lg[s] = lg; m_off[s] = 32'd0;
    endtask

    task automatic check_all_offsets(string req);
        for (int s = 0; s < 8; s++) begin
            rd_slot = 3'(s);
            #1;
            check(req, rd_offset, m_off[s]);
        end
    endtask

    task automatic request(int d, int len);
        logic [31:0] sub, eoff, exp_addr;
        logic        exp_rej;
        sub = m_sub(m_lg[d]);
        exp_rej = (32'(len) > sub);
        if (exp_rej) eoff = m_off[d];
        else if (32'(len) > sub - m_off[d]) eoff = 32'd0;
        else eoff = m_off[d];
        exp_addr = m_base[d] + 32'(own_slot) * sub + eoff;
        @(negedge clk);
        req_valid = 1'b1; req_dst = 3'(d); req_len = 16'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_rej) begin
            check("R6 reject pulse", 32'(reject), 32'd1);
            check("R6 no grant", 32'(grant), 32'd0);
        end else begin
            check("R2 grant pulse", 32'(grant), 32'd1);
            check("R2 no reject", 32'(reject), 32'd0);
            check("R3 grant address", grant_addr, exp_addr);
            m_off[d] = eoff + 32'(len);
        end
        rd_slot = 3'(d);
        #1;
        check("R4/R5/R6 offset readback", rd_offset, m_off[d]);
        @(negedge clk);
        check("R2 single cycle grant", 32'(grant | reject), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; cfg_we = 1'b0; cfg_slot = '0; cfg_base = '0; cfg_range_log2 = '0;
        rd_slot = '0; own_slot = 3'd2; req_valid = 1'b0; req_dst = '0; req_len = '0;
        for (int s = 0; s < 8; s++) begin
            m_base[s] = '0; m_lg[s] = '0; m_off[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 no grant after reset", 32'(grant), 32'd0);
        check_all_offsets("R1 offset zero after reset");

        for (int s = 0; s < 8; s++)
            configure(s, 32'h1000_0000 + 32'(s) * 32'h0010_0000, 5'd10);

        // sub-window 128 bytes
        request(3, 100);
        request(3, 28);            // exact fit, R4 no wrap
        request(3, 1);             // wrap, R5
        request(3, 127);           // exact fill after wrap
        request(3, 0);             // zero length
        request(3, 128);           // whole window, wraps
        request(3, 129);           // R6 too large
        check_all_offsets("R7 other destinations untouched");

        own_slot = 3'd7;
        request(5, 50);
        request(5, 80);            // R5 wrap
        own_slot = 3'd0;
        request(6, 128);

        configure(3, 32'hFFFF_F000, 5'd6);   // R8 clears offset, sub 8
        rd_slot = 3'd3;
        #1;
        check("R8 offset cleared by config", rd_offset, 32'd0);
        request(3, 8);
        request(3, 9);                        // R6
        configure(4, 32'h2000_0000, 5'd2);   // sub 0
        request(4, 1);                        // R6
        request(4, 0);                        // zero length fits zero window

        for (int i = 0; i < 400; i++) begin
            int d, sub;
            if (($urandom % 40) == 0)
                configure(int'($urandom % 8), $urandom, 5'($urandom_range(6, 12)));
            own_slot = 3'($urandom % 8);
            d = int'($urandom % 8);
            sub = int'(m_sub(m_lg[d]));
            request(d, int'($urandom_range(0, sub + sub / 4)));
        end
        check_all_offsets("R7 final offsets");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule